// File: doc/BRIEF.md
# DRAM Rank Boundary Address Decoder

This block turns a physical address into a channel number, a rank index and a page-size code for a memory system with two channels of four ranks each. Software loads the layout through a small byte-wide write port. Each channel holds cumulative rank top addresses in 32 MiB units, plus a page-size code for every rank. A rank whose top equals the one below it is empty and occupies no addresses.

The block compares the two channels on every cycle. When their rank tops and page-size codes match exactly, the channels are interleaved: the system boundaries are twice the channel-0 boundaries, and address bit 7 chooses the channel. When they differ, the layout is asymmetric: channel 0 covers the bottom of the address space and channel 1 sits directly above the channel-0 total.

Each request returns one registered response on the next cycle. The response gives the channel, the rank, the page-size code, and a miss flag for addresses that fall outside populated memory or in a rank whose code is not a legal page size.

Top module: `rank_boundary_decoder`

## Requirements
- R1: Configuration writes take effect on the clock edge where `cfg_we` is high. The `cfg_addr` map is:
  - Addresses 0 to 3 hold the channel-0 rank tops for ranks 0 to 3.
  - Addresses 4 to 7 hold the channel-1 rank tops for ranks 0 to 3.
  - Addresses 8 and 9 hold the channel-0 code bytes for rank pairs 0/1 and 2/3.
  - Addresses 10 and 11 hold the same code bytes for channel 1.
  - Writes to addresses 12 to 15 change nothing.
- R2: In a code byte, bits 2:0 hold the code of the even rank and bits 6:4 hold the code of the odd rank. Bits 3 and 7 are ignored and never affect decoding or the interleave decision.
- R3: `ilv_mode` is 1 exactly when all four rank tops and all four page-size codes of channel 0 equal those of channel 1. The flag reflects the registers from the cycle after any write. After reset all registers are zero, so the flag is 1.
- R4: In interleaved mode, rank r covers system units below 2×top0[r]. A unit is 32 MiB, that is, address bits above bit 24. `rsp_chan` equals request address bit 7.
- R5: In asymmetric mode, addresses below top0[3] units decode to channel 0. Addresses at or above top0[3] units decode to channel 1, using the offset (unit − top0[3]) against the channel-1 tops.
- R6: The selected rank is the lowest-numbered rank whose top exceeds the offset. A rank whose top equals the previous top is never selected.
- R7: The response is a miss (`rsp_miss`=1, `rsp_chan`=0, `rsp_rank`=0, `rsp_pgsz`=0) in either of two cases:
  - The address is at or above the populated total.
  - The selected rank's code is not one of 010, 011 or 100.
- R8: On a hit, `rsp_pgsz` carries the selected rank's 3-bit code. The encodings are 010 for 4 KB, 011 for 8 KB and 100 for 16 KB.
- R9: `rsp_valid` is high in exactly the cycle after `req_valid` was high. The response fields hold their values while no request arrives.
- R10: After reset, `rsp_valid` and all response fields are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| req_valid | input | 1 | Address request valid |
| req_addr | input | 34 | Physical byte address |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_miss | output | 1 | Address not mapped to a usable rank |
| rsp_chan | output | 1 | Selected channel |
| rsp_rank | output | 2 | Selected rank within the channel |
| rsp_pgsz | output | 3 | Page-size code of the selected rank |
| ilv_mode | output | 1 | Channels configured identically (interleaved) |

## Verification
The hardest situations to reach are the ones where the mode decision and the stacking interact. Examples are an address just past the channel-0 total in asymmetric mode, and a rank skipped because its top repeats the previous one. These only appear once the registers of both channels have been written into a particular shape. The stimulus therefore builds a symmetric layout with an empty rank, then breaks symmetry with a single channel-1 write. It also shows that reserved code bits and unmapped register writes leave the mode unchanged. It then probes each rank edge on both sides. A random phase mixes register writes, including paired identical writes that flip the mode back, with requests compared every clock against a behavioural model.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
   localparam logic [2:0] PG_NONE = 3'b000;
   localparam logic [2:0] PG_4K   = 3'b010;
   localparam logic [2:0] PG_8K   = 3'b011;
   localparam logic [2:0] PG_16K  = 3'b100;

   function automatic logic pg_legal(input logic [2:0] code);
      return (code == PG_4K) || (code == PG_8K) || (code == PG_16K);
   endfunction
endpackage

// File: rtl/rbd_cfg_regs.sv
module rbd_cfg_regs #(
   parameter int RANKS  = 4,
   parameter int BND_W  = 8,
   parameter int CFG_AW = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_we,
   input  logic [CFG_AW-1:0]             cfg_addr,
   input  logic [BND_W-1:0]              cfg_wdata,
   output logic [RANKS-1:0][BND_W-1:0]   bnd_c0,
   output logic [RANKS-1:0][BND_W-1:0]   bnd_c1,
   output logic [RANKS-1:0][2:0]         pg_c0,
   output logic [RANKS-1:0][2:0]         pg_c1,
   output logic                          ilv
);
   localparam int PAIRS     = RANKS / 2;
   localparam int ATTR_BASE = 2 * RANKS;

   if ((RANKS % 2) != 0) begin : g_bad_ranks
      $error("RANKS must be even");
   end
   if (3 * RANKS > (1 << CFG_AW)) begin : g_bad_aw
      $error("CFG_AW too narrow for the register map");
   end
   if (BND_W < 7) begin : g_bad_bw
      $error("BND_W must hold a full code byte");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bnd_c0 <= '0;
         bnd_c1 <= '0;
         pg_c0  <= '0;
         pg_c1  <= '0;
      end else if (cfg_we) begin
         for (int r = 0; r < RANKS; r++) begin
            if (cfg_addr == CFG_AW'(r))         bnd_c0[r] <= cfg_wdata;
            if (cfg_addr == CFG_AW'(RANKS + r)) bnd_c1[r] <= cfg_wdata;
         end
         for (int p = 0; p < PAIRS; p++) begin
            if (cfg_addr == CFG_AW'(ATTR_BASE + p)) begin
               pg_c0[2*p]   <= cfg_wdata[2:0];
               pg_c0[2*p+1] <= cfg_wdata[6:4];
            end
            if (cfg_addr == CFG_AW'(ATTR_BASE + PAIRS + p)) begin
               pg_c1[2*p]   <= cfg_wdata[2:0];
               pg_c1[2*p+1] <= cfg_wdata[6:4];
            end
         end
      end
   end

   // symmetric population enables interleaving
   assign ilv = (bnd_c0 == bnd_c1) && (pg_c0 == pg_c1);

   p_bnd_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == '0) |=> (bnd_c0[0] == $past(cfg_wdata)));

   p_odd_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == CFG_AW'(ATTR_BASE)) |=> (pg_c0[1] == $past(cfg_wdata[6:4])));
endmodule

// File: rtl/rbd_rank_search.sv
module rbd_rank_search #(
   parameter int RANKS = 4,
   parameter int UW    = 9,
   parameter int IDX_W = $clog2(RANKS)
) (
   input  logic [UW-1:0]             off,
   input  logic [RANKS-1:0][UW-1:0]  bnd,
   output logic                      hit,
   output logic [IDX_W-1:0]          idx
);
   logic [RANKS-1:0] below;

   for (genvar gr = 0; gr < RANKS; gr++) begin : g_cmp
      assign below[gr] = off < bnd[gr];
   end

   // lowest rank whose top lies above the offset
   always_comb begin
      idx = '0;
      for (int r = RANKS - 1; r >= 0; r--) begin
         if (below[r]) idx = IDX_W'(r);
      end
   end

   assign hit = |below;
endmodule

// File: rtl/rank_boundary_decoder.sv
module rank_boundary_decoder #(
   parameter int RANKS      = 4,
   parameter int BND_W      = 8,
   parameter int GRAN_SHIFT = 25,
   parameter int ADDR_W     = 34,
   parameter int ILV_BIT    = 7,
   parameter int CFG_AW     = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cfg_we,
   input  logic [CFG_AW-1:0]            cfg_addr,
   input  logic [BND_W-1:0]             cfg_wdata,
   input  logic                         req_valid,
   input  logic [ADDR_W-1:0]            req_addr,
   output logic                         rsp_valid,
   output logic                         rsp_miss,
   output logic                         rsp_chan,
   output logic [$clog2(RANKS)-1:0]     rsp_rank,
   output logic [2:0]                   rsp_pgsz,
   output logic                         ilv_mode
);
   localparam int UW    = ADDR_W - GRAN_SHIFT;
   localparam int IDX_W = $clog2(RANKS);

   if (UW < BND_W + 1) begin : g_bad_addr
      $error("ADDR_W too narrow for doubled boundaries");
   end
   if (ILV_BIT >= GRAN_SHIFT) begin : g_bad_ilv
      $error("ILV_BIT must lie below the boundary granule");
   end

   logic [RANKS-1:0][BND_W-1:0] bnd_c0, bnd_c1;
   logic [RANKS-1:0][2:0]       pg_c0, pg_c1;
   logic                        ilv;

   rbd_cfg_regs #(.RANKS(RANKS), .BND_W(BND_W), .CFG_AW(CFG_AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .bnd_c0(bnd_c0), .bnd_c1(bnd_c1),
      .pg_c0(pg_c0), .pg_c1(pg_c1), .ilv(ilv));

   assign ilv_mode = ilv;

   logic [UW-1:0]             unit_a, c0_total, hi_off;
   logic [RANKS-1:0][UW-1:0]  lo_bnd, hi_bnd;
   logic                      use_hi, lo_hit, hi_hit;
   logic [IDX_W-1:0]          lo_idx, hi_idx;

   assign unit_a   = req_addr[ADDR_W-1:GRAN_SHIFT];
   assign c0_total = UW'(bnd_c0[RANKS-1]);
   assign use_hi   = !ilv && (unit_a >= c0_total);
   assign hi_off   = unit_a - c0_total;

   always_comb begin
      for (int r = 0; r < RANKS; r++) begin
         lo_bnd[r] = ilv ? UW'({bnd_c0[r], 1'b0}) : UW'(bnd_c0[r]);
         hi_bnd[r] = UW'(bnd_c1[r]);
      end
   end

   rbd_rank_search #(.RANKS(RANKS), .UW(UW)) u_lo (
      .off(unit_a), .bnd(lo_bnd), .hit(lo_hit), .idx(lo_idx));

   rbd_rank_search #(.RANKS(RANKS), .UW(UW)) u_hi (
      .off(hi_off), .bnd(hi_bnd), .hit(hi_hit), .idx(hi_idx));

   logic             d_chan, d_hit, d_miss;
   logic [IDX_W-1:0] d_rank;
   logic [2:0]       d_pg;

   always_comb begin
      d_chan = ilv ? req_addr[ILV_BIT] : use_hi;
      d_hit  = use_hi ? hi_hit : lo_hit;
      d_rank = use_hi ? hi_idx : lo_idx;
      d_pg   = d_chan ? pg_c1[d_rank] : pg_c0[d_rank];
      d_miss = !d_hit || !rbd_pkg::pg_legal(d_pg);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_miss  <= 1'b0;
         rsp_chan  <= 1'b0;
         rsp_rank  <= '0;
         rsp_pgsz  <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_miss <= d_miss;
            rsp_chan <= d_miss ? 1'b0 : d_chan;
            rsp_rank <= d_miss ? '0 : d_rank;
            rsp_pgsz <= d_miss ? rbd_pkg::PG_NONE : d_pg;
         end
      end
   end

   // previous-rank tops for the empty-rank check
   logic [UW-1:0] lo_prev, hi_prev;
   assign lo_prev = (lo_idx == '0) ? '0 : lo_bnd[IDX_W'(lo_idx - 1'b1)];
   assign hi_prev = (hi_idx == '0) ? '0 : hi_bnd[IDX_W'(hi_idx - 1'b1)];

   p_lo_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lo_hit |-> (lo_bnd[lo_idx] != lo_prev));

   p_hi_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hi_hit |-> (hi_bnd[hi_idx] != hi_prev));

   p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(rsp_rank) && $stable(rsp_chan) &&
                      $stable(rsp_miss) && $stable(rsp_pgsz)));

   p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_miss) |-> (rsp_rank == '0 && !rsp_chan && rsp_pgsz == '0));

   p_page_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_miss) |-> rbd_pkg::pg_legal(rsp_pgsz));

   p_ilv_chan_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ilv_mode) |=> (rsp_miss || rsp_chan == $past(req_addr[ILV_BIT])));
endmodule

// File: tb/rank_boundary_decoder_tb.sv
`timescale 1ns/1ps
module rank_boundary_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic [33:0] req_addr = '0;
   logic        rsp_valid, rsp_miss, rsp_chan, ilv_mode;
   logic [1:0]  rsp_rank;
   logic [2:0]  rsp_pgsz;

   always #2 clk = ~clk;

   rank_boundary_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_miss(rsp_miss), .rsp_chan(rsp_chan),
      .rsp_rank(rsp_rank), .rsp_pgsz(rsp_pgsz), .ilv_mode(ilv_mode));

   int n_cmp = 0, n_bad = 0;
   bit cmp_on = 0, done = 0;
   string cur_tag = "R10 reset";

   // behavioural model of the register contents
   int b0[4], b1[4], p0[4], p1[4];
   initial for (int i = 0; i < 4; i++) begin b0[i] = 0; b1[i] = 0; p0[i] = 0; p1[i] = 0; end

   function automatic bit ref_ilv();
      for (int i = 0; i < 4; i++)
         if (b0[i] != b1[i] || p0[i] != p1[i]) return 0;
      return 1;
   endfunction

   function automatic logic [6:0] ref_dec(logic [33:0] a);
      int u = int'(a >> 25);
      int ch = 0, rk = -1, pg = 0, off;
      if (ref_ilv()) begin
         for (int r = 0; r < 4; r++) if (rk < 0 && u < 2*b0[r]) rk = r;
         ch = int'(a[7]);
      end else if (u < b0[3]) begin
         for (int r = 0; r < 4; r++) if (rk < 0 && u < b0[r]) rk = r;
      end else begin
         off = u - b0[3];
         ch = 1;
         for (int r = 0; r < 4; r++) if (rk < 0 && off < b1[r]) rk = r;
      end
      if (rk >= 0) pg = (ch == 1) ? p1[rk] : p0[rk];
      if (rk < 0 || !(pg == 2 || pg == 3 || pg == 4)) return 7'b1_0_00_000;
      return {1'b0, ch[0], rk[1:0], pg[2:0]};
   endfunction

   always @(posedge clk) if (rst_n && cfg_we) begin
      case (cfg_addr)
         4'd0, 4'd1, 4'd2, 4'd3: b0[cfg_addr] <= int'(cfg_wdata);
         4'd4, 4'd5, 4'd6, 4'd7: b1[cfg_addr-4] <= int'(cfg_wdata);
         4'd8, 4'd9: begin
            p0[2*(cfg_addr-8)]   <= int'(cfg_wdata[2:0]);
            p0[2*(cfg_addr-8)+1] <= int'(cfg_wdata[6:4]);
         end
         4'd10, 4'd11: begin
            p1[2*(cfg_addr-10)]   <= int'(cfg_wdata[2:0]);
            p1[2*(cfg_addr-10)+1] <= int'(cfg_wdata[6:4]);
         end
         default: ;
      endcase
   end

   logic       exp_v = 1'b0;
   logic [6:0] exp_f = '0;
   always @(posedge clk) if (rst_n) begin
      exp_v <= req_valid;
      if (req_valid) exp_f <= ref_dec(req_addr);
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) if (cmp_on) begin
      chk({"R9 valid / ", cur_tag}, 32'(rsp_valid), 32'(exp_v));
      chk({"R7 R8 fields / ", cur_tag}, 32'({rsp_miss, rsp_chan, rsp_rank, rsp_pgsz}), 32'(exp_f));
      chk({"R3 mode / ", cur_tag}, 32'(ilv_mode), 32'(ref_ilv()));
   end

   task automatic wr(int a, int d);
      @(negedge clk); cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 8'(d);
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic rq(int u, int low);
      @(negedge clk); req_valid = 1'b1; req_addr = {9'(u), 25'(low)};
      @(negedge clk); req_valid = 1'b0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 rsp_valid", 32'(rsp_valid), 0);
      chk("R10 fields", 32'({rsp_miss, rsp_chan, rsp_rank, rsp_pgsz}), 0);
      chk("R3 reset mode", 32'(ilv_mode), 1);
      rst_n = 1'b1;
      @(negedge clk); cmp_on = 1;

      // R1 R3 R6: symmetric layout with rank 2 empty
      cur_tag = "R1 R3 load";
      wr(0, 4); wr(1, 8); wr(2, 8); wr(3, 16);
      wr(4, 4); wr(5, 8); wr(6, 8); wr(7, 16);
      wr(8, 8'h32); wr(9, 8'h40); wr(10, 8'h32); wr(11, 8'h40);
      chk("R3 symmetric", 32'(ilv_mode), 1);

      // R4 R6: interleaved decoding across edges
      cur_tag = "R4 R6 interleaved";
      rq(0, 0); rq(0, 'h80); rq(7, 'h1FFFF80); rq(8, 0);
      rq(15, 'h1FFFFFF); rq(16, 'h80); rq(31, 0);
      cur_tag = "R7 beyond total";
      rq(32, 0); rq(300, 'h80);

      // R2: reserved code bits ignored
      cur_tag = "R2 reserved bits";
      wr(8, 8'hBA);
      chk("R2 mode kept", 32'(ilv_mode), 1);
      rq(0, 'h80); rq(8, 0);

      // R1: unmapped writes have no effect
      cur_tag = "R1 unmapped";
      for (int a = 12; a < 16; a++) wr(a, 8'hFF);
      chk("R1 mode kept", 32'(ilv_mode), 1);
      rq(8, 'h80); rq(20, 0);

      // R5: break symmetry, channel 1 stacks above channel-0 total
      cur_tag = "R5 asymmetric";
      wr(7, 20);
      chk("R5 mode asym", 32'(ilv_mode), 0);
      rq(15, 'h80); rq(16, 0); rq(19, 0); rq(20, 0);
      rq(24, 0); rq(35, 'h1FFFFFF); rq(36, 0);

      // R7 R8: reserved and zero codes on populated ranks
      cur_tag = "R7 R8 codes";
      wr(11, 8'h52); rq(16, 0); rq(30, 0);
      wr(8, 8'h30); rq(0, 0); rq(5, 0);

      // random mix
      cur_tag = "R4 R5 R6 random";
      for (int i = 0; i < 2000; i++) begin
         int pick = $urandom_range(0, 9);
         if (pick == 0) wr($urandom_range(0, 15), $urandom_range(0, 255));
         else if (pick == 1) begin
            int a = $urandom_range(0, 3);
            int d = $urandom_range(0, 40);
            wr(a, d); wr(a + 4, d);
         end else if (pick == 2) begin
            int d = $urandom_range(0, 127);
            wr(8 + (i % 2), d); wr(10 + (i % 2), d);
         end else rq($urandom_range(0, 90), $urandom_range(0, 'h1FFFFFF));
      end
      repeat (3) @(negedge clk);
      done = 1;
      summary();
      $finish;
   end
endmodule